// File: doc/BRIEF.md
# Adaptive Divider-Dither Noise Canceller

This block cleans the phase-error word of a digital fractional-N synthesizer by removing the part of it that comes from dithering the feedback divider. One sample arrives per reference cycle. Each sample carries three values: the modulator's input, its quantized output, and the measured phase-error word. The difference between the two modulator values is a frequency error. The block integrates that difference into a phase error, scales it by a learned gain, and subtracts the result from the measured word. The cleaned word goes to the loop filter.

The gain is learned in the digital domain and needs no analog calibration. A correlator multiplies the cleaned residual by the integrated error. That product, divided by a programmable power of two, is added into a gain accumulator. A first-order lowpass then smooths the accumulator before its value is used. When the dither noise is fully removed, the correlation averages to zero and the gain stops moving. Learning is enabled only when the loop has entered fine tuning. Outside that phase, the accumulator is frozen while cancellation continues with the last learned gain.

Top module: `qnoise_canceller`

## Requirements
- R1: After reset, `res_out` and `gain_out` are both 0.
- R2: While the smoothed gain is 0, `res_out` equals the `tdc_in` of the last accepted sample, one clock after the edge on which `smp_vld` was high.
- R3: While `smp_vld` and `clr` are low, `res_out`, `gain_out` and all internal state hold their values.
- R4: On each accepted sample the phase accumulator adds `sd_in - sd_out`. It saturates at +32767 and -32768 and never wraps.
- R5: The residual is `tdc_in - floor(A * G / 256)`, where A is the phase accumulator including the current sample and G is the smoothed gain as it stood before the sample. G is signed with 8 fraction bits. The residual is registered onto `res_out`.
- R6: When `adapt_en` is 1, each sample adds `floor(residual * A / 2^mu_shift)` to the gain accumulator. The accumulator is 16 bits signed and saturates at +32767 and -32768.
- R7: When `adapt_en` is 0, the gain accumulator does not change. `gain_out` then settles and stays constant.
- R8: On each sample the smoother updates `gain_out += floor((S - gain_out) / 2^iir_shift)`, where S is the gain accumulator value from before that sample.
- R9: If `tdc_in = floor(K * A / 256)` and the error pattern has zero mean, adaptation drives `gain_out` to within 16 LSB of K, for K of either sign. `|res_out|` then stays at or below 64.
- R10: `clr` zeroes the phase accumulator, the gain accumulator, the smoother and `res_out`. It takes priority over a sample in the same cycle.
- R11: A residual beyond the 16-bit range is clamped to +32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all state |
| smp_vld | input | 1 | One-cycle strobe that accepts a sample |
| adapt_en | input | 1 | Enables gain learning |
| mu_shift | input | 5 | Correlator step-size shift |
| iir_shift | input | 4 | Smoother shift |
| sd_in | input | 16 | Modulator input, signed |
| sd_out | input | 16 | Modulator quantized output, signed |
| tdc_in | input | 16 | Measured phase-error word, signed |
| res_out | output | 16 | Cleaned phase error, signed |
| gain_out | output | 16 | Smoothed gain, signed, 8 fraction bits |

## Verification
The bench builds a phase-error stream with a known gain on the integrated error, for both a positive and a negative gain. If the correlation had the wrong sign, or if `sd_out` were dropped from the error, the gain would diverge or settle far from the target. Exact single-step checks pin down the step-size shift and the smoother arithmetic, including whether the smoother reads the accumulator before or after the update. Saturation is driven in three places. A wrapping phase accumulator would produce a negative gain step, a wrapping gain would flip sign, and a wrapping residual would turn a large positive error negative. Further checks cover the freeze under `adapt_en` low, the hold with no strobe, and a clear that arrives together with a sample.

// File: rtl/qnc_pkg.sv
// Shared helpers for the quantization noise canceller.
// Assumes every intermediate value fits in 64 bits signed.
package qnc_pkg;

    // Clamp a wide signed value into the range of a w-bit signed field.
    function automatic logic signed [63:0] clamp_s(input logic signed [63:0] v, input int w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/qnc_phase_acc.sv
// Phase accumulator: integrates the modulator quantization error.
// acc_nx is the value including the current sample; the register
// takes it on an accepted sample. Saturates, never wraps.
module qnc_phase_acc
    import qnc_pkg::*;
#(
    parameter int QW = 16,
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 smp_vld,
    input  logic signed [QW-1:0] sd_in,
    input  logic signed [QW-1:0] sd_out,
    output logic signed [AW-1:0] acc_q,
    output logic signed [AW-1:0] acc_nx
);
    logic signed [63:0] qerr;
    logic signed [63:0] acc_sum;
    logic signed [63:0] acc_clamped;

    // Purpose: form the error and its saturated running sum.
    always_comb begin
        qerr        = 64'(sd_in) - 64'(sd_out);
        acc_sum     = 64'(acc_q) + qerr;
        acc_clamped = clamp_s(acc_sum, AW);
        acc_nx      = acc_clamped[AW-1:0];
    end

    // Purpose: hold the phase state between samples.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (clr)     acc_q <= '0;
        else if (smp_vld) acc_q <= acc_nx;
    end

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && (sd_in > sd_out)) |=> (acc_q >= $past(acc_q))); // R4
    AST_ACC_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && (sd_in < sd_out)) |=> (acc_q <= $past(acc_q))); // R4

endmodule

// File: rtl/qnc_cancel.sv
// Cancellation path: subtracts the scaled phase error from the
// measured word and registers the saturated residual.
// Assumes the gain carries GF fraction bits.
module qnc_cancel
    import qnc_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 16,
    parameter int GW = 16,
    parameter int GF = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 smp_vld,
    input  logic signed [AW-1:0] acc_nx,
    input  logic signed [GW-1:0] gain_s,
    input  logic signed [PW-1:0] tdc_in,
    output logic signed [PW-1:0] resid,
    output logic signed [PW-1:0] res_q
);
    logic signed [63:0] scaled;
    logic signed [63:0] corr_term;
    logic signed [63:0] diff;
    logic signed [63:0] diff_c;

    // Purpose: compute the saturated residual for this sample.
    always_comb begin
        scaled    = 64'(acc_nx) * 64'(gain_s);
        corr_term = scaled >>> GF;
        diff      = 64'(tdc_in) - corr_term;
        diff_c    = clamp_s(diff, PW);
        resid     = diff_c[PW-1:0];
    end

    // Purpose: register the residual on an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (clr)     res_q <= '0;
        else if (smp_vld) res_q <= resid;
    end

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !clr) |=> $stable(res_q)); // R3
    AST_RES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (res_q == '0)); // R10

endmodule

// File: rtl/qnc_lms.sv
// Correlator and gain accumulator: correlates the residual with the
// phase error, scales the product by 2^-mu_shift and integrates it.
// Adapts only while adapt_en is high. Saturates at GW bits.
module qnc_lms
    import qnc_pkg::*;
#(
    parameter int AW  = 16,
    parameter int PW  = 16,
    parameter int GW  = 16,
    parameter int MUW = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  smp_vld,
    input  logic                  adapt_en,
    input  logic        [MUW-1:0] mu_shift,
    input  logic signed [PW-1:0]  resid,
    input  logic signed [AW-1:0]  acc_nx,
    output logic signed [GW-1:0]  gacc_q
);
    logic signed [63:0] corr;
    logic signed [63:0] step;
    logic signed [63:0] gsum;
    logic signed [63:0] gsum_c;
    logic signed [GW-1:0] gacc_nx;

    // Purpose: correlate, apply the step size and integrate with saturation.
    always_comb begin
        corr    = 64'(resid) * 64'(acc_nx);
        step    = corr >>> mu_shift;
        gsum    = 64'(gacc_q) + step;
        gsum_c  = clamp_s(gsum, GW);
        gacc_nx = gsum_c[GW-1:0];
    end

    // Purpose: update the gain accumulator only while learning.
    always_ff @(posedge clk) begin
        if (!rst_n)                   gacc_q <= '0;
        else if (clr)                 gacc_q <= '0;
        else if (smp_vld && adapt_en) gacc_q <= gacc_nx;
    end

    AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!adapt_en && !clr) |=> $stable(gacc_q)); // R7
    AST_ZERO_RESID_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && (resid == '0)) |=> $stable(gacc_q)); // R6

endmodule

// File: rtl/qnc_iir.sv
// First-order smoother: y += (x - y) >>> k on each accepted sample.
// x is the registered gain accumulator, so the update sees the value
// from before the current sample.
module qnc_iir #(
    parameter int GW = 16,
    parameter int KW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 smp_vld,
    input  logic        [KW-1:0] iir_shift,
    input  logic signed [GW-1:0] x,
    output logic signed [GW-1:0] y_q
);
    logic signed [63:0] delta;
    logic signed [63:0] y_sum;
    logic signed [GW-1:0] y_nx;

    // Purpose: move the state a shifted fraction toward the target.
    always_comb begin
        delta = 64'(x) - 64'(y_q);
        y_sum = 64'(y_q) + (delta >>> iir_shift);
        y_nx  = y_sum[GW-1:0];
    end

    // Purpose: hold the smoothed gain.
    always_ff @(posedge clk) begin
        if (!rst_n)       y_q <= '0;
        else if (clr)     y_q <= '0;
        else if (smp_vld) y_q <= y_nx;
    end

    AST_IIR_UP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && (x >= y_q)) |=> ((y_q >= $past(y_q)) && (y_q <= $past(x)))); // R8
    AST_IIR_DOWN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !clr && (x < y_q)) |=> ((y_q <= $past(y_q)) && (y_q >= $past(x)))); // R8
    AST_IIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (y_q == '0)); // R10

endmodule

// File: rtl/qnoise_canceller.sv
// Top: removes divider-dither quantization noise from a phase-error
// stream with a gain learned by correlation. One sample per smp_vld.
// Assumes smp_vld is a single-cycle strobe per reference cycle.
module qnoise_canceller #(
    parameter int QW  = 16,
    parameter int AW  = 16,
    parameter int PW  = 16,
    parameter int GW  = 16,
    parameter int GF  = 8,
    parameter int MUW = 5,
    parameter int KW  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 smp_vld,
    input  logic                 adapt_en,
    input  logic [MUW-1:0]       mu_shift,
    input  logic [KW-1:0]        iir_shift,
    input  logic signed [QW-1:0] sd_in,
    input  logic signed [QW-1:0] sd_out,
    input  logic signed [PW-1:0] tdc_in,
    output logic signed [PW-1:0] res_out,
    output logic signed [GW-1:0] gain_out
);
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] acc_nx;
    logic signed [PW-1:0] resid;
    logic signed [GW-1:0] gacc_q;
    logic signed [GW-1:0] gain_s;

    qnc_phase_acc #(.QW(QW), .AW(AW)) u_pacc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .sd_in(sd_in), .sd_out(sd_out), .acc_q(acc_q), .acc_nx(acc_nx)
    );

    qnc_cancel #(.AW(AW), .PW(PW), .GW(GW), .GF(GF)) u_canc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .acc_nx(acc_nx), .gain_s(gain_s), .tdc_in(tdc_in),
        .resid(resid), .res_q(res_out)
    );

    qnc_lms #(.AW(AW), .PW(PW), .GW(GW), .MUW(MUW)) u_lms (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .adapt_en(adapt_en), .mu_shift(mu_shift), .resid(resid),
        .acc_nx(acc_nx), .gacc_q(gacc_q)
    );

    qnc_iir #(.GW(GW), .KW(KW)) u_iir (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .iir_shift(iir_shift), .x(gacc_q), .y_q(gain_s)
    );

    assign gain_out = gain_s;

    AST_IDLE_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld && !clr) |=> ($stable(gain_out) && $stable(acc_q))); // R3

endmodule

// File: tb/sim_qnoise_canceller.sv
`timescale 1ns/1ps
module sim_qnoise_canceller;
    logic clk = 1'b0;
    logic rst_n, clr, smp_vld, adapt_en;
    logic [4:0] mu_shift;
    logic [3:0] iir_shift;
    logic signed [15:0] sd_in, sd_out, tdc_in;
    logic signed [15:0] res_out, gain_out;

    int n_chk = 0;
    int n_bad = 0;
    int acc_m = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    qnoise_canceller u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .adapt_en(adapt_en), .mu_shift(mu_shift), .iir_shift(iir_shift),
        .sd_in(sd_in), .sd_out(sd_out), .tdc_in(tdc_in),
        .res_out(res_out), .gain_out(gain_out)
    );

    // Pass-through vectors (gain 0): sd_in, sd_out, tdc_in, expected res_out
    localparam int VN = 6;
    localparam int V_SI[VN] = '{100, -7, 3000, 0, -20000, 5};
    localparam int V_SO[VN] = '{1, 7, -3000, 0, 10000, 5};
    localparam int V_T [VN] = '{1234, -1, 32767, -32768, 0, -500};
    localparam int V_E [VN] = '{1234, -1, 32767, -32768, 0, -500};
    localparam int PAT[4]   = '{600, 400, -400, -600};

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic do_sample(input int si, input int so, input int t);
        @(negedge clk);
        sd_in = 16'(si); sd_out = 16'(so); tdc_in = 16'(t); smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        acc_m = sat16(acc_m + si - so);
    endtask

    task automatic do_clear(input int t);
        @(negedge clk);
        clr = 1'b1; smp_vld = 1'b1; sd_in = 16'sd1000; sd_out = '0; tdc_in = 16'(t);
        @(negedge clk);
        clr = 1'b0; smp_vld = 1'b0;
        acc_m = 0;
    endtask

    // Known-gain stream: tdc = floor(K * A / 256), A the phase after the sample.
    task automatic run_gain(input int k, input int n, output int max_res);
        max_res = 0;
        for (int i = 0; i < n; i++) begin
            int q, nxt, t;
            q   = PAT[i % 4];
            nxt = sat16(acc_m + q);
            t   = (k * nxt) >>> 8;
            do_sample(q + 3, 3, t);
            if (iabs(int'(res_out)) > max_res) max_res = iabs(int'(res_out));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int g1, mr;
        rst_n = 1'b0; clr = 1'b0; smp_vld = 1'b0; adapt_en = 1'b0;
        mu_shift = 5'd14; iir_shift = 4'd1;
        sd_in = '0; sd_out = '0; tdc_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 res", int'(res_out), 0);
        check_eq("R1 gain", int'(gain_out), 0);

        // Vector table: pass-through with zero gain, learning off
        for (int i = 0; i < VN; i++) begin
            do_sample(V_SI[i], V_SO[i], V_T[i]);
            check_eq("R2", int'(res_out), V_E[i]);
            check_eq("R7 gain stays 0", int'(gain_out), 0);
        end

        // R3: no strobe, outputs hold
        @(negedge clk); tdc_in = 16'sd999; sd_in = 16'sd50;
        repeat (3) @(negedge clk);
        check_eq("R3 hold", int'(res_out), V_E[VN-1]);

        // R10 clear with simultaneous sample, then exact step and smoother checks
        do_clear(4321);
        check_eq("R10 res cleared", int'(res_out), 0);
        check_eq("R10 gain cleared", int'(gain_out), 0);
        adapt_en = 1'b1; mu_shift = 5'd10; iir_shift = 4'd2;
        do_sample(500, 0, 1000);
        check_eq("R5 first residual", int'(res_out), 1000);
        check_eq("R8 smoother lags", int'(gain_out), 0);
        do_sample(-500, 0, 0);
        check_eq("R8 first smooth step", int'(gain_out), 122);
        do_sample(0, 0, 0);
        check_eq("R8 second smooth step", int'(gain_out), 213);

        // R6: step-size shift with immediate smoother
        do_clear(0);
        mu_shift = 5'd12; iir_shift = 4'd0;
        do_sample(500, 0, 1000);
        do_sample(-500, 0, 0);
        check_eq("R6 step shift", int'(gain_out), 122);

        // R6: gain accumulator saturation, both signs
        do_clear(0);
        mu_shift = 5'd0;
        do_sample(30000, 0, 30000);
        do_sample(-30000, 0, 0);
        check_eq("R6 sat high", int'(gain_out), 32767);
        do_clear(0);
        do_sample(30000, 0, -30000);
        do_sample(-30000, 0, 0);
        check_eq("R6 sat low", int'(gain_out), -32768);

        // R4: phase accumulator saturates instead of wrapping
        do_clear(0);
        mu_shift = 5'd15;
        do_sample(20000, 0, 0);
        do_sample(20000, 0, 0);
        do_sample(0, 0, 1000);
        check_eq("R4 residual", int'(res_out), 1000);
        do_sample(0, 0, 0);
        check_eq("R4 acc saturated", int'(gain_out), 999);

        // R9: convergence to a positive gain
        do_clear(0);
        adapt_en = 1'b1; mu_shift = 5'd14; iir_shift = 4'd1;
        run_gain(384, 600, mr);
        check_rng("R9 gain +1.5", int'(gain_out), 384 - 16, 384 + 16);
        run_gain(384, 8, mr);
        check_rng("R9 residual small", mr, 0, 64);

        // R7: freeze
        adapt_en = 1'b0;
        run_gain(384, 40, mr);
        g1 = int'(gain_out);
        run_gain(384, 40, mr);
        check_eq("R7 frozen gain", int'(gain_out), g1);
        check_rng("R7 still cancels", mr, 0, 64);

        // R9: convergence to a negative gain
        do_clear(0);
        adapt_en = 1'b1;
        run_gain(-256, 600, mr);
        check_rng("R9 gain -1.0", int'(gain_out), -256 - 16, -256 + 16);

        // R11: residual clamping, learning off
        adapt_en = 1'b0;
        run_gain(-256, 40, mr);
        do_sample(1000, 0, 32000);
        check_eq("R11 clamp high", int'(res_out), 32767);
        do_sample(-2000, 0, -32000);
        check_eq("R11 clamp low", int'(res_out), -32768);

        // R10: clear after a learned gain
        do_clear(0);
        check_eq("R10 gain cleared again", int'(gain_out), 0);
        do_sample(0, 0, 777);
        check_eq("R10 pass-through after clear", int'(res_out), 777);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule